// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block sits between the interrupt sources of a chip and one processor. It keeps a single pending slot, packed with the processor's current priority threshold into one 32-bit readable word. It also keeps a software inter-processor interrupt (IPI) priority and a hidden priority for whatever is in the slot. Sources offer interrupts with a number and a priority. The block either takes the offer into the slot or hands it back on a reject port. When a better candidate arrives, it evicts the one it holds. Evicted or refused sources are returned for the source side to retry later; nothing is queued inside.

The processor drives single-cycle commands: accept, set threshold, set IPI priority, end-of-interrupt and poll. Accept and poll show the packed word on the read port during the strobe cycle. Accept, set threshold, set IPI priority and end-of-interrupt change the state on the next clock. The block drives a level interrupt line to the processor. It also has an end-of-interrupt notify port and a resend-request strobe, which asks the source side to offer again whatever it had to hold back.

Top module: `irq_presenter`

## Requirements
- R1: After reset the packed word (threshold in bits 31:24, pending source in bits 23:0) is zero, the IPI priority reads 0xFF, the hidden pending priority is 0xFF and `irq_o` is low. Priority 0 is most favoured and 0xFF is least favoured or masked. A source field of zero means empty.
- R2: An offer is refused if its priority is greater than or equal to the threshold, or if the slot holds a source whose pending priority is less than or equal to the offer's. The refused number appears on reject lane 1 (`rej_src_o` bits 47:24) one clock later.
- R3: An offer that is not refused takes the slot: the number and priority are stored and `irq_o` rises on the next clock. A non-IPI source that it displaces appears on reject lane 1.
- R4: `cmd_op`=1 (accept): `rd_data_o` shows the packed word in the strobe cycle. On the next clock the threshold equals the old pending priority, the source field is zero, the pending priority is 0xFF and `irq_o` is low.
- R5: `cmd_op`=2 (set threshold, value in `cmd_data` bits 7:0) with a value below the old threshold cancels a pending source whose pending priority is greater than or equal to the new value. The slot empties, `irq_o` drops and a non-IPI source appears on reject lane 0 (bits 23:0).
- R6: A set-threshold command with a value greater than or equal to the old threshold, while the slot is empty, pulses `resend_o` one clock later. If the IPI priority is below the new threshold, the IPI fills the slot.
- R7: `cmd_op`=3 (set IPI priority, value in bits 7:0) stores the value. If it is below the threshold, the IPI (number `IPI_SRC`, default 2) takes the slot unless the slot holds a source of equal or more favoured priority. A displaced non-IPI source appears on reject lane 0.
- R8: `cmd_op`=4 (end-of-interrupt) sets the threshold to `cmd_data` bits 31:24 and puts bits 23:0 on `eoi_src_o` with `eoi_valid_o` one clock later. If the slot is empty, it performs the resend of R6 against the new threshold.
- R9: The IPI number is never presented on either reject lane.
- R10: `cmd_op`=5 (poll), an idle `cmd_op` value (0, 6 or 7), or a low `cmd_valid` leaves all state unchanged. `rd_ipi_o` always shows the IPI priority.
- R11: When a command and an offer fall in the same cycle, the command acts first and the offer is judged against the resulting state. Both reject lanes may then fire together.
- R12: `irq_o` is high exactly when the source field of the packed word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Offer strobe |
| offer_src | input | 24 | Offered source number (nonzero, not the IPI number) |
| offer_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Command operand |
| rd_data_o | output | 32 | Packed threshold and pending source |
| rd_ipi_o | output | 8 | IPI priority |
| irq_o | output | 1 | Level interrupt to processor |
| rej_valid_o | output | 2 | Reject lane valids (bit 0 command, bit 1 offer) |
| rej_src_o | output | 48 | Reject lane source numbers |
| eoi_valid_o | output | 1 | End-of-interrupt notify strobe |
| eoi_src_o | output | 24 | Completed source number |
| resend_o | output | 1 | Resend request strobe |

## Verification
A processor command and a source offer can fall in the same clock. The cases that matter are a threshold change or an IPI write that rearranges the slot in the same cycle as an offer competing for it. The bench provokes this both with a directed case and with random stimulus that sets both strobes independently. A bench model applies the command first and the offer second. It then compares the slot, the line and both reject lanes one clock later.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;
   typedef enum logic [2:0] {
      OP_IDLE     = 3'd0,
      OP_ACCEPT   = 3'd1,
      OP_SET_THR  = 3'd2,
      OP_SET_IPI  = 3'd3,
      OP_EOI      = 3'd4,
      OP_POLL     = 3'd5
   } pres_op_e;
endpackage

// File: rtl/pres_ipi_arb.sv
module pres_ipi_arb #(
   parameter int SRC_W   = 24,
   parameter int PRIO_W  = 8,
   parameter int IPI_SRC = 2
) (
   input  logic [SRC_W-1:0]  src_i,
   input  logic [PRIO_W-1:0] pend_i,
   input  logic [PRIO_W-1:0] ipi_prio_i,
   output logic              take_o,
   output logic [SRC_W-1:0]  src_o,
   output logic [PRIO_W-1:0] pend_o,
   output logic              rej_o,
   output logic [SRC_W-1:0]  rej_src_o
);
   localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);
   logic held;
   always_comb begin
      held      = (src_i != '0) && (pend_i <= ipi_prio_i);
      take_o    = !held;
      src_o     = held ? src_i : IPI_NUM;
      pend_o    = held ? pend_i : ipi_prio_i;
      rej_o     = !held && (src_i != '0) && (src_i != IPI_NUM);
      rej_src_o = src_i;
   end
endmodule

// File: rtl/pres_cmd_stage.sv
module pres_cmd_stage
   import irq_presenter_pkg::*;
#(
   parameter int SRC_W   = 24,
   parameter int PRIO_W  = 8,
   parameter int IPI_SRC = 2
) (
   input  logic                    cmd_valid,
   input  logic [2:0]              cmd_op,
   input  logic [SRC_W+PRIO_W-1:0] cmd_data,
   input  logic [PRIO_W-1:0]       thr_i,
   input  logic [SRC_W-1:0]        src_i,
   input  logic [PRIO_W-1:0]       pend_i,
   input  logic [PRIO_W-1:0]       ipi_i,
   input  logic                    irq_i,
   output logic [PRIO_W-1:0]       thr_o,
   output logic [SRC_W-1:0]        src_o,
   output logic [PRIO_W-1:0]       pend_o,
   output logic [PRIO_W-1:0]       ipi_o,
   output logic                    irq_o,
   output logic                    rej_o,
   output logic [SRC_W-1:0]        rej_src_o,
   output logic                    eoi_o,
   output logic [SRC_W-1:0]        eoi_src_o,
   output logic                    resend_o
);
   localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);
   localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

   pres_op_e          op;
   logic [PRIO_W-1:0] val;
   logic [PRIO_W-1:0] hi_field;
   logic [PRIO_W-1:0] ipi_sel;
   logic              a_take, a_rej;
   logic [SRC_W-1:0]  a_src, a_rej_src;
   logic [PRIO_W-1:0] a_pend;

   assign op       = pres_op_e'(cmd_op);
   assign val      = cmd_data[PRIO_W-1:0];
   assign hi_field = cmd_data[SRC_W+PRIO_W-1:SRC_W];
   assign ipi_sel  = (cmd_valid && op == OP_SET_IPI) ? val : ipi_i;

   pres_ipi_arb #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_arb (
      .src_i(src_i), .pend_i(pend_i), .ipi_prio_i(ipi_sel),
      .take_o(a_take), .src_o(a_src), .pend_o(a_pend),
      .rej_o(a_rej), .rej_src_o(a_rej_src)
   );

   always_comb begin
      thr_o = thr_i; src_o = src_i; pend_o = pend_i; ipi_o = ipi_i; irq_o = irq_i;
      rej_o = 1'b0; rej_src_o = src_i;
      eoi_o = 1'b0; eoi_src_o = cmd_data[SRC_W-1:0];
      resend_o = 1'b0;
      if (cmd_valid) begin
         unique case (op)
            OP_ACCEPT: begin
               thr_o = pend_i; src_o = '0; pend_o = PRIO_NONE; irq_o = 1'b0;
            end
            OP_SET_THR: begin
               thr_o = val;
               if (val < thr_i) begin
                  if (src_i != '0 && val <= pend_i) begin
                     src_o = '0; pend_o = PRIO_NONE; irq_o = 1'b0;
                     rej_o = (src_i != IPI_NUM);
                  end
               end else if (src_i == '0) begin
                  resend_o = 1'b1;
                  if (ipi_i < val) begin
                     src_o = a_src; pend_o = a_pend; irq_o = 1'b1;
                  end
               end
            end
            OP_SET_IPI: begin
               ipi_o = val;
               if (val < thr_i && a_take) begin
                  src_o = a_src; pend_o = a_pend; irq_o = 1'b1;
                  rej_o = a_rej; rej_src_o = a_rej_src;
               end
            end
            OP_EOI: begin
               thr_o = hi_field;
               eoi_o = 1'b1;
               if (src_i == '0) begin
                  resend_o = 1'b1;
                  if (ipi_i < hi_field) begin
                     src_o = a_src; pend_o = a_pend; irq_o = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pres_offer_stage.sv
module pres_offer_stage #(
   parameter int SRC_W   = 24,
   parameter int PRIO_W  = 8,
   parameter int IPI_SRC = 2
) (
   input  logic              offer_valid,
   input  logic [SRC_W-1:0]  offer_src,
   input  logic [PRIO_W-1:0] offer_prio,
   input  logic [PRIO_W-1:0] thr_i,
   input  logic [SRC_W-1:0]  src_i,
   input  logic [PRIO_W-1:0] pend_i,
   input  logic              irq_i,
   output logic [SRC_W-1:0]  src_o,
   output logic [PRIO_W-1:0] pend_o,
   output logic              irq_o,
   output logic              rej_o,
   output logic [SRC_W-1:0]  rej_src_o
);
   localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);
   logic refuse;
   always_comb begin
      src_o = src_i; pend_o = pend_i; irq_o = irq_i;
      rej_o = 1'b0; rej_src_o = offer_src;
      refuse = (offer_prio >= thr_i) || ((src_i != '0) && (pend_i <= offer_prio));
      if (offer_valid) begin
         if (refuse) begin
            rej_o = 1'b1;
         end else begin
            rej_o     = (src_i != '0) && (src_i != IPI_NUM);
            rej_src_o = src_i;
            src_o = offer_src; pend_o = offer_prio; irq_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
   import irq_presenter_pkg::*;
#(
   parameter int SRC_W   = 24,
   parameter int PRIO_W  = 8,
   parameter int IPI_SRC = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    offer_valid,
   input  logic [SRC_W-1:0]        offer_src,
   input  logic [PRIO_W-1:0]       offer_prio,
   input  logic                    cmd_valid,
   input  logic [2:0]              cmd_op,
   input  logic [SRC_W+PRIO_W-1:0] cmd_data,
   output logic [SRC_W+PRIO_W-1:0] rd_data_o,
   output logic [PRIO_W-1:0]       rd_ipi_o,
   output logic                    irq_o,
   output logic [1:0]              rej_valid_o,
   output logic [2*SRC_W-1:0]      rej_src_o,
   output logic                    eoi_valid_o,
   output logic [SRC_W-1:0]        eoi_src_o,
   output logic                    resend_o
);
   localparam int                LANES     = 2;
   localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);
   localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

   initial begin
      assert (SRC_W >= 2 && PRIO_W >= 1)
         else $error("irq_presenter: widths too small");
      assert (IPI_SRC > 0 && IPI_SRC < (1 << SRC_W))
         else $error("irq_presenter: IPI number must be nonzero and fit the source field");
   end

   logic [PRIO_W-1:0] thr_q, pend_q, ipi_q;
   logic [SRC_W-1:0]  src_q;
   logic              irq_q;

   logic [PRIO_W-1:0] c_thr, c_pend, c_ipi, o_pend;
   logic [SRC_W-1:0]  c_src, o_src;
   logic              c_irq, o_irq;
   logic [LANES-1:0]  lane_v;
   logic [SRC_W-1:0]  lane_s [LANES];
   logic              c_eoi, c_resend;
   logic [SRC_W-1:0]  c_eoi_src;

   pres_cmd_stage #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_cmd (
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .thr_i(thr_q), .src_i(src_q), .pend_i(pend_q), .ipi_i(ipi_q), .irq_i(irq_q),
      .thr_o(c_thr), .src_o(c_src), .pend_o(c_pend), .ipi_o(c_ipi), .irq_o(c_irq),
      .rej_o(lane_v[0]), .rej_src_o(lane_s[0]),
      .eoi_o(c_eoi), .eoi_src_o(c_eoi_src), .resend_o(c_resend)
   );

   pres_offer_stage #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_offer (
      .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
      .thr_i(c_thr), .src_i(c_src), .pend_i(c_pend), .irq_i(c_irq),
      .src_o(o_src), .pend_o(o_pend), .irq_o(o_irq),
      .rej_o(lane_v[1]), .rej_src_o(lane_s[1])
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q <= '0; src_q <= '0; pend_q <= PRIO_NONE; ipi_q <= PRIO_NONE; irq_q <= 1'b0;
         eoi_valid_o <= 1'b0; eoi_src_o <= '0; resend_o <= 1'b0;
      end else begin
         thr_q <= c_thr; src_q <= o_src; pend_q <= o_pend; ipi_q <= c_ipi; irq_q <= o_irq;
         eoi_valid_o <= c_eoi; eoi_src_o <= c_eoi_src; resend_o <= c_resend;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rej_valid_o[g] <= 1'b0;
            rej_src_o[g*SRC_W +: SRC_W] <= '0;
         end else begin
            rej_valid_o[g] <= lane_v[g];
            rej_src_o[g*SRC_W +: SRC_W] <= lane_s[g];
         end
      end
      assert_no_ipi_reject_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         rej_valid_o[g] |-> rej_src_o[g*SRC_W +: SRC_W] != IPI_NUM);
   end

   assign rd_data_o = {thr_q, src_q};
   assign rd_ipi_o  = ipi_q;
   assign irq_o     = irq_q;

   assert_line_tracks_slot_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (src_q != '0));
   assert_empty_slot_prio_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == '0) |-> pend_q == PRIO_NONE);
   assert_accept_empties_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'(OP_ACCEPT) && !offer_valid) |=> (src_q == '0 && !irq_o));
   assert_refuse_low_prio_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (offer_valid && !cmd_valid && offer_prio >= thr_q)
         |=> (rej_valid_o[1] && rej_src_o[2*SRC_W-1:SRC_W] == $past(offer_src) && $stable(src_q)));
   assert_poll_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'(OP_POLL) && !offer_valid)
         |=> ($stable(rd_data_o) && $stable(rd_ipi_o) && !rej_valid_o[0]));
   assert_eoi_forward_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'(OP_EOI))
         |=> (eoi_valid_o && eoi_src_o == $past(cmd_data[SRC_W-1:0])));
endmodule

// File: tb/irq_presenter_tb_top.sv
`timescale 1ns/1ps
module irq_presenter_tb_top;
   localparam int SW = 24;
   localparam int PW = 8;
   localparam int IPI = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic offer_valid = 1'b0;
   logic [SW-1:0] offer_src = '0;
   logic [PW-1:0] offer_prio = '0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [SW+PW-1:0] cmd_data = '0;
   logic [SW+PW-1:0] rd_data_o;
   logic [PW-1:0] rd_ipi_o;
   logic irq_o;
   logic [1:0] rej_valid_o;
   logic [2*SW-1:0] rej_src_o;
   logic eoi_valid_o;
   logic [SW-1:0] eoi_src_o;
   logic resend_o;

   always #4 clk = ~clk;

   irq_presenter dut_i (
      .clk(clk), .rst_n(rst_n),
      .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .rd_data_o(rd_data_o), .rd_ipi_o(rd_ipi_o), .irq_o(irq_o),
      .rej_valid_o(rej_valid_o), .rej_src_o(rej_src_o),
      .eoi_valid_o(eoi_valid_o), .eoi_src_o(eoi_src_o), .resend_o(resend_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   logic [PW-1:0] m_thr, m_pend, m_ipi;
   logic [SW-1:0] m_src;
   logic m_irq;
   logic [1:0] e_rv;
   logic [SW-1:0] e_rs0, e_rs1, e_eois;
   logic e_eoiv, e_resend;
   string tag_state;

   task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic ipi_try();
      if (!(m_src != 0 && m_pend <= m_ipi)) begin
         if (m_src != 0 && m_src != SW'(IPI)) begin e_rv[0] = 1; e_rs0 = m_src; end
         m_src = SW'(IPI); m_pend = m_ipi; m_irq = 1;
      end
   endtask

   task automatic model_step(input bit cv, input logic [2:0] op, input logic [31:0] d,
                             input bit ov, input logic [SW-1:0] os, input logic [PW-1:0] opr);
      logic [PW-1:0] old_thr;
      e_rv = 0; e_eoiv = 0; e_resend = 0; tag_state = "R10";
      if (cv) begin
         case (op)
            3'd1: begin tag_state = "R4"; m_thr = m_pend; m_src = 0; m_pend = 8'hFF; m_irq = 0; end
            3'd2: begin
               old_thr = m_thr; m_thr = d[7:0];
               if (d[7:0] < old_thr) begin
                  tag_state = "R5";
                  if (m_src != 0 && d[7:0] <= m_pend) begin
                     if (m_src != SW'(IPI)) begin e_rv[0] = 1; e_rs0 = m_src; end
                     m_src = 0; m_pend = 8'hFF; m_irq = 0;
                  end
               end else begin
                  tag_state = "R6";
                  if (m_src == 0) begin e_resend = 1; if (m_ipi < m_thr) ipi_try(); end
               end
            end
            3'd3: begin tag_state = "R7"; m_ipi = d[7:0]; if (m_ipi < m_thr) ipi_try(); end
            3'd4: begin
               tag_state = "R8"; m_thr = d[31:24]; e_eoiv = 1; e_eois = d[23:0];
               if (m_src == 0) begin e_resend = 1; if (m_ipi < m_thr) ipi_try(); end
            end
            default: ;
         endcase
      end
      if (ov) begin
         tag_state = cv ? "R11" : "R3";
         if (opr >= m_thr || (m_src != 0 && m_pend <= opr)) begin
            if (!cv) tag_state = "R2";
            e_rv[1] = 1; e_rs1 = os;
         end else begin
            if (m_src != 0 && m_src != SW'(IPI)) begin e_rv[1] = 1; e_rs1 = m_src; end
            m_src = os; m_pend = opr; m_irq = 1;
         end
      end
   endtask

   task automatic check_all();
      cmp(tag_state, "packed word", 64'(rd_data_o), 64'({m_thr, m_src}));
      cmp("R10", "ipi prio", 64'(rd_ipi_o), 64'(m_ipi));
      cmp("R12", "irq line", 64'(irq_o), 64'(m_irq));
      cmp("R5", "lane0 valid", 64'(rej_valid_o[0]), 64'(e_rv[0]));
      if (e_rv[0]) cmp("R9", "lane0 src", 64'(rej_src_o[SW-1:0]), 64'(e_rs0));
      cmp("R2", "lane1 valid", 64'(rej_valid_o[1]), 64'(e_rv[1]));
      if (e_rv[1]) cmp("R3", "lane1 src", 64'(rej_src_o[2*SW-1:SW]), 64'(e_rs1));
      cmp("R8", "eoi valid", 64'(eoi_valid_o), 64'(e_eoiv));
      if (e_eoiv) cmp("R8", "eoi src", 64'(eoi_src_o), 64'(e_eois));
      cmp("R6", "resend", 64'(resend_o), 64'(e_resend));
   endtask

   // drive at negedge, update model, then check one clock later at negedge
   task automatic step(input bit cv, input logic [2:0] op, input logic [31:0] d,
                       input bit ov, input logic [SW-1:0] os, input logic [PW-1:0] opr);
      cmd_valid = cv; cmd_op = op; cmd_data = d;
      offer_valid = ov; offer_src = os; offer_prio = opr;
      if (cv && op == 3'd1) cmp("R4", "accept read", 64'(rd_data_o), 64'({m_thr, m_src}));
      model_step(cv, op, d, ov, os, opr);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 0; offer_valid = 0;
      check_all();
   endtask

   function automatic logic [PW-1:0] rnd_prio();
      int r = $urandom % 10;
      return (r == 9) ? 8'hFF : PW'(r);
   endfunction

   function automatic logic [SW-1:0] rnd_src();
      int r = $urandom % 40;
      return SW'(r + 3);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      m_thr = 0; m_src = 0; m_pend = 8'hFF; m_ipi = 8'hFF; m_irq = 0;
      e_rv = 0; e_rs0 = 0; e_rs1 = 0; e_eois = 0; e_eoiv = 0; e_resend = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      cmp("R1", "reset word", 64'(rd_data_o), 64'h0);
      cmp("R1", "reset ipi", 64'(rd_ipi_o), 64'hFF);
      cmp("R1", "reset irq", 64'(irq_o), 64'h0);
      cmp("R1", "reset side outputs", 64'({rej_valid_o, eoi_valid_o, resend_o}), 64'h0);
      // directed corner cases
      step(1, 3'd2, 32'hFF, 0, 0, 0);           // R6 raise threshold, empty, resend
      step(0, 0, 0, 1, 24'd100, 8'd5);          // R3 take slot
      step(0, 0, 0, 1, 24'd200, 8'd5);          // R2 equal pending refuses
      step(0, 0, 0, 1, 24'd300, 8'd3);          // R3 displaces 100
      step(0, 0, 0, 1, 24'd400, 8'hFF);         // R2 at threshold refuses
      step(1, 3'd1, 0, 0, 0, 0);                // R4 accept
      step(1, 3'd4, {8'hFF, 24'd300}, 0, 0, 0); // R8 eoi with resend
      step(1, 3'd3, 32'd4, 0, 0, 0);            // R7 IPI takes slot
      step(0, 0, 0, 1, 24'd500, 8'd1);          // R9 IPI displaced, not rejected
      step(1, 3'd2, 32'd1, 0, 0, 0);            // R5 cancel 500
      step(1, 3'd2, 32'hFF, 0, 0, 0);           // R6 IPI refills
      step(1, 3'd2, 32'd4, 0, 0, 0);            // R5 cancel IPI, R9 no reject
      step(1, 3'd5, 0, 0, 0, 0);                // R10 poll
      step(1, 3'd7, 32'h12, 0, 0, 0);           // R10 idle code
      step(1, 3'd2, 32'hFF, 1, 24'd600, 8'd2);  // R11 command then offer
      step(1, 3'd3, 32'd6, 0, 0, 0);            // R7 IPI blocked by better pending
      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit cv = ($urandom % 3) != 0;
         logic [2:0] op = 3'($urandom % 8);
         logic [31:0] d;
         if (op == 3'd4) d = {rnd_prio(), ($urandom % 4 == 0) ? 24'd0 : rnd_src()};
         else d = {24'($urandom), rnd_prio()};
         step(cv, op, d, ($urandom % 2) == 1, rnd_src(), rnd_prio());
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule